// File: doc/BRIEF.md
# Packed-Nibble Pixel Unpacker with Palette

This block sits between a video memory fetch path and a colour DAC. Video memory stores two 4-bit pixel indices in every byte, so the memory only has to deliver one byte every two dot clocks, half the rate of a one-byte-per-pixel layout. The block takes each fetched byte, splits it into its two indices, and maps each index through a writable 16-entry colour table. It puts out one 8-bit colour per dot clock. The colour is packed as red in bits 7:6, green in bits 5:4, blue in bits 3:2 and intensity in bits 1:0.

The fetch side offers a byte with a valid strobe and sees a ready signal. The block accepts a new byte in the cycle in which the low nibble of the previous byte is being looked up. A steady source therefore yields an unbroken pixel stream. A processor-side write port replaces table entries at any time. A blanking input forces the output colour to zero. Sync generation and memory address sequencing lie outside this block.

Top module: `nibble_palette_unpacker`

## Requirements
- R1: A byte accepted at clock edge N shows the table entry indexed by its bits 7:4 on `pix_col` after edge N+2, and the entry indexed by its bits 3:0 after edge N+3.
- R2: `byte_ready` is low for exactly the one cycle after an accepting edge and is high otherwise. A byte offered at every ready edge therefore produces a new colour on every clock with no gaps.
- R3: A byte presented with `byte_valid` high while `byte_ready` is low is not taken, and the output stream shows no trace of it.
- R4: A table write sampled at edge W leaves the output after edge W+1 unchanged. From the output after edge W+2 onward, every use of that index shows the new value.
- R5: After reset, table entry n holds a grey ramp. For n = {a[1:0], b[1:0]}, the entry is {a, a, a, b}, so 0x0 maps to 0x00, 0x5 to 0x55, 0xC to 0xFC and 0xF to 0xFF.
- R6: When `blank` is high at edge N, `pix_col` is 0x00 after edge N+1, whatever pixel occupies that slot. The byte stream still advances.
- R7: When no nibble is pending (no byte accepted or stream drained), `pix_col` is 0x00.
- R8: While `rst` is high and right after its release, `pix_col` is 0x00 and `byte_ready` is high.
- R9: The output colour is the stored 8-bit entry bit for bit, with no reordering of the RRGGBBII fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A packed byte is offered |
| byte_data | input | 8 | Packed byte: first pixel in bits 7:4, second in bits 3:0 |
| byte_ready | output | 1 | Block takes the offered byte at this edge |
| blank | input | 1 | Forces the corresponding output pixel to black |
| pal_we | input | 1 | Colour table write strobe |
| pal_idx | input | 4 | Colour table entry to write |
| pal_col | input | 8 | Colour value to store (RRGGBBII) |
| pix_col | output | 8 | Output colour per dot clock (RRGGBBII) |

## Verification
A table of packed bytes streams back to back. The table mixes bytes whose two halves differ in every bit (0xF0, 0x0F), patterns that catch nibble swaps (0x5A, 0x3C) and irregular pairs, so a swapped order, a stuck nibble or a wrong ramp entry each give a distinct colour. On every cycle with ready low, the bench offers the bitwise inverse of the real byte, so a sequencer that took it would show foreign colours. Directed runs apply a one-cycle blank in the middle of a steady stream, a table rewrite timed one cycle before the affected index is read, and an idle tail after the last byte.

// File: rtl/nibpal_pkg.sv
package nibpal_pkg;

  // Which half of the held byte the sequencer presents this cycle.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } nib_phase_e;

  // Reset grey ramp for 4-bit index / RRGGBBII colour:
  // upper index bits drive all three channels, lower bits drive intensity.
  function automatic logic [7:0] grey_ramp(input logic [3:0] n);
    return {n[3:2], n[3:2], n[3:2], n[1:0]};
  endfunction

endpackage

// File: rtl/nib_seq.sv
module nib_seq #(
  parameter int IDX_W = 4,
  localparam int BYTE_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_act
);
  import nibpal_pkg::*;

  nib_phase_e        phase_q;
  logic [BYTE_W-1:0] hold_q;
  logic              take;

  // A byte can be taken in idle or while the low half is being used.
  assign in_ready = (phase_q != PH_HI);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      hold_q  <= '0;
    end else if (take) begin
      hold_q  <= in_byte;
      phase_q <= PH_HI;
    end else if (phase_q == PH_HI) begin
      phase_q <= PH_LO;
    end else begin
      phase_q <= PH_IDLE;
    end
  end

  assign cur_idx = (phase_q == PH_HI) ? hold_q[BYTE_W-1:IDX_W] : hold_q[IDX_W-1:0];
  assign cur_act = (phase_q != PH_IDLE);

  // R2
  take_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !in_ready);

  // R1
  high_half_first_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (cur_idx == $past(in_byte[BYTE_W-1:IDX_W])));

  // R1
  low_half_second_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> ##1 (cur_idx == $past(in_byte[IDX_W-1:0], 2)));

endmodule

// File: rtl/nib_palette.sv
module nib_palette #(
  parameter int IDX_W = 4,
  parameter int COL_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [COL_W-1:0] wr_col,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [COL_W-1:0] rd_col
);

  logic [COL_W-1:0] table_q [DEPTH];
  logic             live_q;

  function automatic logic [COL_W-1:0] reset_col(input int n);
    if (IDX_W == 4 && COL_W == 8)
      return COL_W'(nibpal_pkg::grey_ramp(4'(n)));
    else
      return COL_W'(n);
  endfunction

  // Write port: entries reload the ramp on reset, else one write per clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) table_q[i] <= reset_col(i);
    end else if (wr_en) begin
      table_q[wr_idx] <= wr_col;
    end
  end

  // Registered read, old data on a same-cycle collision.
  always_ff @(posedge clk) begin
    if (rst) rd_col <= '0;
    else     rd_col <= table_q[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  // R4
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(wr_en) && (rd_idx == $past(wr_idx))) |=> (rd_col == $past(wr_col, 2)));

endmodule

// File: rtl/nib_colour_out.sv
module nib_colour_out #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] col_in,
  input  logic             act_in,
  input  logic             blank_in,
  output logic [COL_W-1:0] pix_out
);

  logic act_q;
  logic blank_q;

  // Qualifiers are sampled on the same edge as the table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      blank_q <= 1'b0;
      pix_out <= '0;
    end else begin
      act_q   <= act_in;
      blank_q <= blank_in;
      pix_out <= (act_q && !blank_q) ? col_in : '0;
    end
  end

  // R6
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    blank_in |=> ##1 (pix_out == '0));

  // R7
  idle_black_chk: assert property (@(posedge clk) disable iff (rst)
    !act_in |=> ##1 (pix_out == '0));

endmodule

// File: rtl/nibble_palette_unpacker.sv
module nibble_palette_unpacker #(
  parameter int IDX_W = 4,
  parameter int COL_W = 8,
  localparam int BYTE_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              byte_ready,
  input  logic              blank,
  input  logic              pal_we,
  input  logic [IDX_W-1:0]  pal_idx,
  input  logic [COL_W-1:0]  pal_col,
  output logic [COL_W-1:0]  pix_col
);

  logic [IDX_W-1:0] sel_idx;
  logic             sel_act;
  logic [COL_W-1:0] lut_col;

  nib_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (byte_valid),
    .in_byte  (byte_data),
    .in_ready (byte_ready),
    .cur_idx  (sel_idx),
    .cur_act  (sel_act)
  );

  nib_palette #(.IDX_W(IDX_W), .COL_W(COL_W)) u_pal (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (pal_we),
    .wr_idx (pal_idx),
    .wr_col (pal_col),
    .rd_idx (sel_idx),
    .rd_col (lut_col)
  );

  nib_colour_out #(.COL_W(COL_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .col_in   (lut_col),
    .act_in   (sel_act),
    .blank_in (blank),
    .pix_out  (pix_col)
  );

endmodule

// File: tb/sim_nibble_palette_unpacker.sv
module sim_nibble_palette_unpacker;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       byte_ready;
  logic       blank = 1'b0;
  logic       pal_we = 1'b0;
  logic [3:0] pal_idx = 4'h0;
  logic [7:0] pal_col = 8'h00;
  logic [7:0] pix_col;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nibble_palette_unpacker u0 (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .blank(blank), .pal_we(pal_we), .pal_idx(pal_idx),
    .pal_col(pal_col), .pix_col(pix_col)
  );

  // {byte, expected first colour, expected second colour} from the grey ramp
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    24'hF0_FF_00, 24'h0F_00_FF, 24'h5A_55_AA, 24'h3C_03_FC,
    24'h18_01_A8, 24'h7E_57_FE, 24'h29_02_A9, 24'hBD_AB_FD
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 pix in reset", pix_col, 8'h00);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 pix after reset", pix_col, 8'h00);
    chk("R8 ready after reset", {7'd0, byte_ready}, 8'h01);

    // Vector stream: real byte offered at even cycles, inverse at odd (R3).
    for (int c = 0; c < 2 * NV + 4; c++) begin
      byte_valid = (c / 2 < NV);
      if (c / 2 < NV) byte_data = (c % 2 == 0) ? VEC[c/2][23:16] : ~VEC[c/2][23:16];
      @(posedge clk); @(negedge clk);
      if (c / 2 < NV)
        chk("R2 ready pattern", {7'd0, byte_ready}, (c % 2 == 0) ? 8'h00 : 8'h01);
      if (c >= 2) begin
        if ((c - 2) / 2 < NV)
          chk("R1 R3 R5 R9 stream colour", pix_col,
              (c % 2 == 0) ? VEC[(c-2)/2][15:8] : VEC[(c-2)/2][7:0]);
        else
          chk("R7 drained output", pix_col, 8'h00);
      end
    end
    byte_valid = 1'b0;

    // Blank for one cycle in a steady 0x5A stream.
    for (int c = 0; c < 8; c++) begin
      byte_valid = 1'b1;
      byte_data  = 8'h5A;
      blank      = (c == 4);
      @(posedge clk); @(negedge clk);
      if (c == 5)      chk("R6 blanked slot", pix_col, 8'h00);
      else if (c >= 2) chk("R6 unblanked neighbours", pix_col, (c % 2 == 0) ? 8'h55 : 8'hAA);
    end
    blank = 1'b0;
    byte_valid = 1'b0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R7 idle output", pix_col, 8'h00);

    // Rewrite entry 5 in the middle of a 0x55 stream.
    for (int c = 0; c < 8; c++) begin
      byte_valid = 1'b1;
      byte_data  = 8'h55;
      pal_we     = (c == 3);
      pal_idx    = 4'h5;
      pal_col    = 8'hC3;
      @(posedge clk); @(negedge clk);
      if (c >= 2) chk("R4 R9 write timing", pix_col, (c >= 5) ? 8'hC3 : 8'h55);
    end
    pal_we = 1'b0;
    byte_valid = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule